// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block sits in front of the instruction fetch path. It turns a fetch virtual address into a physical address and reports a single outcome for each request. The outcome is one of: no fault, access violation, page miss or machine check. It also tells the fetch path whether the resulting access must bypass the caches.

Each request is decided in one combinational pass and presented one clock later. The pass picks a route for the request in priority order:

1. Privileged-firmware (PAL) bypass.
2. Physical pass-through.
3. Malformed-address rejection.
4. Kernel superpage direct map.
5. Mapped lookup, which uses a hit, page number and per-mode execute mask returned by an attached translation buffer.

After the route is applied, the physical address is checked against the implemented physical range.

The design has no multi-state controller. Its only sequential state is the response register. It holds Idle (`rsp_valid` low) or Respond (`rsp_valid` high, outcome held). The design moves Idle→Respond or Respond→Respond on any cycle with `req_valid` high. It moves Respond→Idle or stays Idle on any cycle with it low.

Top module: `ifx_xlate`

## Requirements
- R1: While `rst_n` is low, `rsp_valid`, `fault`, `pa` and `uncacheable` are all zero.
- R2: A request with `req_valid` high at a clock edge produces `rsp_valid` high after that edge. A cycle without a request leaves `rsp_valid` low.
- R3: With `pal_mode` high, the result is fault code 2'b00 and `pa` = `va` with bits 1:0 cleared and masked to bits 43:0. This holds whatever the other inputs are.
- R4: With `pal_mode` low and `phys_mode` high, `pa` equals `va` unchanged.
- R5: Otherwise, a `va` whose bits 63:47 are not all equal gives fault code 2'b01 (access violation).
- R6: A canonical `va` with bits 47:41 equal to 7'h7E is a superpage. It gives fault 2'b01 when `cur_mode` is not 0 (0 is kernel).
- R7: A kernel superpage access gives `pa` = `va` masked to bits 43:0. If bit 40 of that value is set, bits 43:40 are forced to 1. Otherwise `pa` is cut to bits 39:0.
- R8: A mapped access with `tb_hit` low gives fault code 2'b10 (page miss).
- R9: On a hit, `pa` = (`tb_ppn` << 13) + (`va`[12:0] with bits 1:0 cleared).
- R10: A hit whose `tb_xre` bit indexed by `cur_mode` is 0 gives fault 2'b01. This check outranks the range check.
- R11: A route that would otherwise succeed gives fault 2'b11 (machine check) when `pa` has any bit set above bit 43. `pa` is still reported in that case.
- R12: `uncacheable` is high exactly when the fault is 2'b00 and `pa`[43] is 1. On faults 2'b01 and 2'b10, `pa` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| va | input | 64 | Fetch virtual address |
| pal_mode | input | 1 | Fetch is in privileged-firmware mode (PC bit 0 set) |
| phys_mode | input | 1 | Request asks for physical addressing |
| cur_mode | input | 2 | Current privilege mode, 0 = kernel |
| tb_hit | input | 1 | Translation buffer found a matching entry |
| tb_ppn | input | 32 | Physical page number from the entry |
| tb_xre | input | 4 | Per-mode execute enable mask from the entry |
| rsp_valid | output | 1 | Result valid |
| fault | output | 2 | 00 none, 01 access violation, 10 page miss, 11 machine check |
| pa | output | 64 | Physical address |
| uncacheable | output | 1 | Access must bypass caches |

## Verification
The bound checker watches, on every cycle, the following properties:
- the one-cycle response timing;
- that a PAL request never faults;
- that a canonical non-superpage miss yields a page miss;
- that a non-machine-check result never carries bits above the physical range;
- that faulting results carry a zero address;
- that the uncacheable flag only accompanies a clean result with bit 43 set.

Some behaviours can only be shown by the bench's directed requests with hand-computed results:
- the exact address arithmetic (PAL low-bit clearing, the superpage extension around bit 40, page-number shift plus offset);
- the per-mode indexing of the execute mask;
- the priority of access violation over machine check.

// File: rtl/ifx_pkg.sv
package ifx_pkg;
    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_ACV  = 2'b01,
        FLT_MISS = 2'b10,
        FLT_MCHK = 2'b11
    } fault_e;

    typedef enum logic [2:0] {
        RT_PAL    = 3'd0,
        RT_PHYS   = 3'd1,
        RT_BADVA  = 3'd2,
        RT_SUPER  = 3'd3,
        RT_MAPPED = 3'd4
    } route_e;
endpackage

// File: rtl/ifx_route_sel.sv
module ifx_route_sel #(
    parameter int          VA_W   = 48,
    parameter int          SP_LO  = 41,
    parameter logic [6:0]  SP_TAG = 7'h7E
) (
    input  logic [63:0]       va,
    input  logic              pal_mode,
    input  logic              phys_mode,
    output ifx_pkg::route_e   route
);
    import ifx_pkg::*;

    localparam int SP_HI = VA_W - 1;
    localparam int SP_W  = SP_HI - SP_LO + 1;

    logic canonical;
    logic in_super;

    always_comb begin
        canonical = (&va[63:VA_W-1]) | ~(|va[63:VA_W-1]);
        in_super  = (va[SP_HI:SP_LO] == SP_W'(SP_TAG));
        if (pal_mode)
            route = RT_PAL;
        else if (phys_mode)
            route = RT_PHYS;
        else if (!canonical)
            route = RT_BADVA;
        else if (in_super)
            route = RT_SUPER;
        else
            route = RT_MAPPED;
    end
endmodule

// File: rtl/ifx_pa_build.sv
module ifx_pa_build #(
    parameter int PA_W        = 44,
    parameter int PG_SHIFT    = 13,
    parameter int PPN_W       = 32,
    parameter bit SP_SIGN_EXT = 1'b1
) (
    input  ifx_pkg::route_e   route,
    input  logic [63:0]       va,
    input  logic [PPN_W-1:0]  ppn,
    output logic [63:0]       raw_pa
);
    import ifx_pkg::*;

    localparam logic [63:0] PA_MASK  = (64'd1 << PA_W) - 64'd1;
    localparam int          EXT_BIT  = PA_W - 4;
    localparam logic [63:0] LOW_MASK = (64'd1 << EXT_BIT) - 64'd1;
    localparam logic [63:0] EXT_ONES = PA_MASK & ~LOW_MASK;
    localparam logic [63:0] OFF_MASK = ((64'd1 << PG_SHIFT) - 64'd1) & ~64'd3;

    logic [63:0] sp_base;
    logic [63:0] sp_pa;
    logic [63:0] map_pa;

    assign sp_base = va & PA_MASK;
    assign map_pa  = (64'(ppn) << PG_SHIFT) + (va & OFF_MASK);

    generate
        if (SP_SIGN_EXT) begin : g_sp_ext
            assign sp_pa = sp_base[EXT_BIT] ? (sp_base | EXT_ONES)
                                            : (sp_base & LOW_MASK);
        end else begin : g_sp_plain
            assign sp_pa = sp_base;
        end
    endgenerate

    always_comb begin
        unique case (route)
            RT_PAL:    raw_pa = va & ~64'd3 & PA_MASK;
            RT_PHYS:   raw_pa = va;
            RT_SUPER:  raw_pa = sp_pa;
            RT_MAPPED: raw_pa = map_pa;
            default:   raw_pa = 64'd0;
        endcase
    end
endmodule

// File: rtl/ifx_fault_eval.sv
module ifx_fault_eval #(
    parameter int PA_W   = 44,
    parameter int MODE_W = 2
) (
    input  ifx_pkg::route_e          route,
    input  logic [MODE_W-1:0]        cur_mode,
    input  logic                     tb_hit,
    input  logic [(1<<MODE_W)-1:0]   tb_xre,
    input  logic [63:0]              raw_pa,
    output ifx_pkg::fault_e          fault,
    output logic [63:0]              pa,
    output logic                     uncacheable
);
    import ifx_pkg::*;

    localparam logic [63:0] PA_MASK = (64'd1 << PA_W) - 64'd1;

    logic    out_of_range;
    fault_e  range_flt;

    assign out_of_range = |(raw_pa & ~PA_MASK);
    assign range_flt    = out_of_range ? FLT_MCHK : FLT_NONE;

    always_comb begin
        unique case (route)
            RT_PAL:    fault = FLT_NONE;
            RT_PHYS:   fault = range_flt;
            RT_BADVA:  fault = FLT_ACV;
            RT_SUPER:  fault = (cur_mode != '0) ? FLT_ACV : range_flt;
            RT_MAPPED: begin
                if (!tb_hit)
                    fault = FLT_MISS;
                else if (!tb_xre[cur_mode])
                    fault = FLT_ACV;
                else
                    fault = range_flt;
            end
            default:   fault = FLT_ACV;
        endcase
        pa          = (fault == FLT_ACV || fault == FLT_MISS) ? 64'd0 : raw_pa;
        uncacheable = (fault == FLT_NONE) && pa[PA_W-1];
    end
endmodule

// File: rtl/ifx_xlate.sv
module ifx_xlate #(
    parameter int MODE_W = 2,
    parameter int PPN_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [63:0]             va,
    input  logic                    pal_mode,
    input  logic                    phys_mode,
    input  logic [MODE_W-1:0]       cur_mode,
    input  logic                    tb_hit,
    input  logic [PPN_W-1:0]        tb_ppn,
    input  logic [(1<<MODE_W)-1:0]  tb_xre,
    output logic                    rsp_valid,
    output logic [1:0]              fault,
    output logic [63:0]             pa,
    output logic                    uncacheable
);
    import ifx_pkg::*;

    localparam int PA_W     = 44;
    localparam int PG_SHIFT = 13;

    route_e      route;
    logic [63:0] raw_pa;
    fault_e      nxt_fault;
    logic [63:0] nxt_pa;
    logic        nxt_unc;

    ifx_route_sel #(.VA_W(48), .SP_LO(41), .SP_TAG(7'h7E)) u_route (
        .va(va), .pal_mode(pal_mode), .phys_mode(phys_mode), .route(route)
    );

    ifx_pa_build #(.PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .PPN_W(PPN_W), .SP_SIGN_EXT(1'b1)) u_pa (
        .route(route), .va(va), .ppn(tb_ppn), .raw_pa(raw_pa)
    );

    ifx_fault_eval #(.PA_W(PA_W), .MODE_W(MODE_W)) u_flt (
        .route(route), .cur_mode(cur_mode), .tb_hit(tb_hit), .tb_xre(tb_xre),
        .raw_pa(raw_pa), .fault(nxt_fault), .pa(nxt_pa), .uncacheable(nxt_unc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            fault       <= FLT_NONE;
            pa          <= 64'd0;
            uncacheable <= 1'b0;
        end else if (req_valid) begin
            rsp_valid   <= 1'b1;
            fault       <= nxt_fault;
            pa          <= nxt_pa;
            uncacheable <= nxt_unc;
        end else begin
            rsp_valid   <= 1'b0;
            fault       <= FLT_NONE;
            pa          <= 64'd0;
            uncacheable <= 1'b0;
        end
    end
endmodule

// File: rtl/ifx_xlate_chk.sv
module ifx_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [63:0] va,
    input logic        pal_mode,
    input logic        phys_mode,
    input logic        tb_hit,
    input logic        rsp_valid,
    input logic [1:0]  fault,
    input logic [63:0] pa,
    input logic        uncacheable
);
    logic plain_map;
    assign plain_map = !pal_mode && !phys_mode &&
                       (va[63:47] == 17'h1FFFF || va[63:47] == 17'h0) &&
                       (va[47:41] != 7'h7E);

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);                                         // R2
    AST_NO_IDLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);                                       // R2
    AST_PAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pal_mode) |=> (fault == 2'b00));                    // R3
    AST_MISS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && plain_map && !tb_hit) |=> (fault == 2'b10));        // R8
    AST_RANGE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && fault != 2'b11) |-> (pa[63:44] == 20'd0));          // R11
    AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (fault == 2'b01 || fault == 2'b10)) |-> (pa == 64'd0)); // R12
    AST_UNC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        uncacheable |-> (rsp_valid && fault == 2'b00 && pa[43]));         // R12
endmodule

bind ifx_xlate ifx_xlate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .va(va),
    .pal_mode(pal_mode), .phys_mode(phys_mode), .tb_hit(tb_hit),
    .rsp_valid(rsp_valid), .fault(fault), .pa(pa), .uncacheable(uncacheable)
);

// File: tb/ifx_xlate_test.sv
module ifx_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] va = 64'd0;
    logic        pal_mode = 1'b0;
    logic        phys_mode = 1'b0;
    logic [1:0]  cur_mode = 2'd0;
    logic        tb_hit = 1'b0;
    logic [31:0] tb_ppn = 32'd0;
    logic [3:0]  tb_xre = 4'd0;
    logic        rsp_valid;
    logic [1:0]  fault;
    logic [63:0] pa;
    logic        uncacheable;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] pa;
        logic [1:0]  flt;
        logic        unc;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    ifx_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .va(va),
        .pal_mode(pal_mode), .phys_mode(phys_mode), .cur_mode(cur_mode),
        .tb_hit(tb_hit), .tb_ppn(tb_ppn), .tb_xre(tb_xre),
        .rsp_valid(rsp_valid), .fault(fault), .pa(pa), .uncacheable(uncacheable)
    );

    task automatic send(input logic [63:0] a, input logic pal, input logic phys,
                        input logic [1:0] md, input logic hit, input logic [31:0] ppn,
                        input logic [3:0] xre, input logic [63:0] e_pa,
                        input logic [1:0] e_flt, input logic e_unc, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; va = a; pal_mode = pal; phys_mode = phys;
        cur_mode = md; tb_hit = hit; tb_ppn = ppn; tb_xre = xre;
        e.pa = e_pa; e.flt = e_flt; e.unc = e_unc; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: shortly after each edge, a queued item must be answered (R2)
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                compared++;
                if (!rsp_valid || pa !== e.pa || fault !== e.flt || uncacheable !== e.unc) begin
                    mismatched++;
                    $display("FAIL %s R2: got v=%0b pa=%h flt=%0d unc=%0b exp v=1 pa=%h flt=%0d unc=%0b",
                             e.tag, rsp_valid, pa, fault, uncacheable, e.pa, e.flt, e.unc);
                end
            end else if (rsp_valid) begin
                compared++;
                mismatched++;
                $display("FAIL R2: got rsp_valid=1 exp 0 with nothing outstanding");
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compared++;
        if (rsp_valid !== 1'b0 || fault !== 2'b00 || pa !== 64'd0 || uncacheable !== 1'b0) begin
            mismatched++;
            $display("FAIL R1: got v=%0b flt=%0d pa=%h unc=%0b exp all zero",
                     rsp_valid, fault, pa, uncacheable);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R3: PAL bypass ignores a missing entry and odd low bits
        send(64'h1234_5678_9ABC_DEF3, 1, 0, 2'd3, 0, 32'd0, 4'd0, 64'h0678_9ABC_DEF0, 2'b00, 0, "R3");
        send(64'h0000_0800_0000_0005, 1, 1, 2'd1, 0, 32'd0, 4'd0, 64'h0800_0000_0004, 2'b00, 1, "R3/R12");
        // R4 / R11 physical pass-through
        send(64'h0000_0123_4567_89AB, 0, 1, 2'd2, 0, 32'd0, 4'd0, 64'h0000_0123_4567_89AB, 2'b00, 0, "R4");
        send(64'h0000_1000_0000_0000, 0, 1, 2'd0, 0, 32'd0, 4'd0, 64'h0000_1000_0000_0000, 2'b11, 0, "R11");
        // R5 malformed address, even with a hit
        send(64'h0001_0000_0000_0000, 0, 0, 2'd0, 1, 32'd1, 4'hF, 64'd0, 2'b01, 0, "R5");
        idle();
        // R6 / R7 superpage
        send(64'hFFFF_FC00_1234_5678, 0, 0, 2'd3, 1, 32'd1, 4'hF, 64'd0, 2'b01, 0, "R6");
        send(64'hFFFF_FC00_1234_5678, 0, 0, 2'd0, 0, 32'd0, 4'd0, 64'h0000_0000_1234_5678, 2'b00, 0, "R7");
        send(64'hFFFF_FD00_0000_2000, 0, 0, 2'd0, 0, 32'd0, 4'd0, 64'h0000_0F00_0000_2000, 2'b00, 1, "R7/R12");
        // R8 miss
        send(64'h0000_0000_0001_0000, 0, 0, 2'd0, 0, 32'h55, 4'hF, 64'd0, 2'b10, 0, "R8");
        // R9 / R10 mapped hits
        send(64'h0000_0000_0000_1ABF, 0, 0, 2'd0, 1, 32'h1234, 4'b0001, 64'h0000_0000_0246_9ABC, 2'b00, 0, "R9");
        send(64'h0000_0000_0000_1ABF, 0, 0, 2'd2, 1, 32'h1234, 4'b1011, 64'd0, 2'b01, 0, "R10");
        send(64'h0000_0000_0000_1ABF, 0, 0, 2'd2, 1, 32'h1234, 4'b0100, 64'h0000_0000_0246_9ABC, 2'b00, 0, "R10");
        idle();
        // R11 mapped out of range, R10 priority over it, R12 uncacheable hit
        send(64'h0000_0000_0000_1ABC, 0, 0, 2'd1, 1, 32'h8000_0000, 4'hF, 64'h0000_1000_0000_1ABC, 2'b11, 0, "R11");
        send(64'h0000_0000_0000_1ABC, 0, 0, 2'd1, 1, 32'h8000_0000, 4'h0, 64'd0, 2'b01, 0, "R10");
        send(64'h0000_0000_0000_0000, 0, 0, 2'd0, 1, 32'h4000_0000, 4'h1, 64'h0000_0800_0000_0000, 2'b00, 1, "R12");
        idle();
        idle();
        idle();
        done = 1'b1;
        if (sb.size() != 0) begin
            compared++;
            mismatched++;
            $display("FAIL R2: got %0d unanswered exp 0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        done = 1'b1;
        compared++;
        mismatched++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule